// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns a free-running oscillator clock into an exact average 1 MHz tick, and then counts those ticks in a free-running microsecond counter. The oscillator may run at a rate that is not a whole multiple of 1 MHz, for example 19.2 MHz or 38.4 MHz. So the block does not use a plain integer divider. It uses a rational ratio: it emits `P` ticks for every `Q` oscillator cycles. The ratio is set by a 16-bit configuration word that holds `P-1` and `Q-1`.

The divider is a fractional accumulator. In every counting cycle it adds `P`. Whenever the sum reaches `Q`, it subtracts `Q` and raises a one-cycle tick. This spreads the ticks as evenly as whole cycles allow. A small two-state machine controls the accumulator.

- `ST_RESTART` is entered from reset and on every configuration write (transition *restart*). It holds the accumulator at zero and emits no tick.
- `ST_COUNT` follows one cycle later (transition *resume*). It accumulates and emits ticks, and it stays there (transition *run*) until the next write.

The microsecond counter is never cleared by a configuration write.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset, `cfg_q` reads the parameter `RST_CFG` (default 0x000B), `usec_count` is 0 and `tick` is low.
- R2: A write (`cfg_wr` high at a rising edge) loads `cfg_wdata` into the register. `cfg_q` shows it after that edge. Bits [15:8] hold `P-1` (ticks per period) and bits [7:0] hold `Q-1` (oscillator cycles per period).
- R3: The edge that takes a write, and the edge after it, both leave `tick` low. During that time the state machine passes through `ST_RESTART` with the accumulator at zero.
- R4: Over the first `Q` counting cycles after a restart (edges 2 to `Q+1` after the write edge), exactly `P` ticks occur whenever `P <= Q`. The settings 0x000B, 0x000C, 0x0019, 0x002F, 0x043F, 0x0453, 0x045F and 0x04BF each give exactly one tick per microsecond on average.
- R5: Consecutive ticks are `floor(Q/P)` or `ceil(Q/P)` cycles apart.
- R6: If `P > Q`, then `P` is treated as `Q`, and `tick` is high in every counting cycle.
- R7: `usec_count` goes up by exactly one at each edge where `tick` goes to or stays high. It holds at every other edge.
- R8: A configuration write leaves `usec_count` unchanged. It is neither cleared nor stepped at the write edge or in the restart cycle.
- R9: The counter wraps from all ones to zero and raises no flag.
- R10: With an integer ratio (upper field 0), the first tick after a write comes at counting cycle `Q`. Later ticks follow every `Q` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | New configuration word: {P-1, Q-1} |
| cfg_q | output | 16 | Current configuration word |
| tick | output | 1 | One-cycle 1 MHz-average tick pulse |
| usec_count | output | 32 | Free-running microsecond count |

## Verification
A write is taken at edge E0. `cfg_q` and the cleared accumulator are visible 1 ns after E0. The restart cycle ends at E1, and the first possible tick and counter step appear after E2. Each directed task drives inputs on the falling edge. It samples 1 ns after each rising edge, reads the counter after E1 and again after edge E(Q+1), and compares the difference with `P`. In the same loop it logs the cycle index of every tick, so that the spacing and the position of the first tick can be checked cycle by cycle. The wrap check uses a second instance with an 8-bit counter and a one-to-one ratio, so that it can watch each step, including 255 to 0.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

    // Accumulator control states
    typedef enum logic [0:0] {
        ST_RESTART = 1'b0,
        ST_COUNT   = 1'b1
    } tick_state_e;

endpackage

// File: rtl/utk_cfg_reg.sv
module utk_cfg_reg #(
    parameter int              FLD_W   = 8,
    parameter logic [2*FLD_W-1:0] RST_CFG = 16'h000B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [2*FLD_W-1:0]   wdata,
    output logic [2*FLD_W-1:0]   cfg_q,
    output logic [FLD_W:0]       num,
    output logic [FLD_W:0]       den
);
    localparam int TERM_W = FLD_W + 1;

    logic [TERM_W-1:0] num_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RST_CFG;
        end else if (wr) begin
            cfg_q <= wdata;
        end
    end

    // n+1 decoding of both fields, tick term clamped to the cycle term
    always_comb begin
        num_raw = {1'b0, cfg_q[2*FLD_W-1:FLD_W]} + TERM_W'(1);
        den     = {1'b0, cfg_q[FLD_W-1:0]} + TERM_W'(1);
        num     = (num_raw > den) ? den : num_raw;
    end

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cfg_q == $past(wdata));

    // R6
    num_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (num <= den) && (num != '0));

endmodule

// File: rtl/utk_frac_acc.sv
module utk_frac_acc
    import usec_tick_pkg::*;
#(
    parameter int FLD_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic [FLD_W:0] num,
    input  logic [FLD_W:0] den,
    output logic           fire,
    output logic           tick
);
    localparam int ACC_W = FLD_W + 1;
    localparam int SUM_W = ACC_W + 1;

    tick_state_e       cur_st;
    tick_state_e       nxt_st;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_nxt;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  rem;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_st <= ST_RESTART;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // Next-state logic: restart, resume, run
    always_comb begin
        nxt_st = cur_st;
        if (restart) begin
            nxt_st = ST_RESTART;
        end else begin
            unique case (cur_st)
                ST_RESTART: nxt_st = ST_COUNT;
                ST_COUNT:   nxt_st = ST_COUNT;
                default:    nxt_st = ST_RESTART;
            endcase
        end
    end

    // Output / datapath logic
    always_comb begin
        sum     = {1'b0, acc} + {1'b0, num};
        rem     = sum - {1'b0, den};
        fire    = 1'b0;
        acc_nxt = '0;
        if (!restart) begin
            unique case (cur_st)
                ST_RESTART: begin
                    fire    = 1'b0;
                    acc_nxt = '0;
                end
                ST_COUNT: begin
                    if (sum >= {1'b0, den}) begin
                        fire    = 1'b1;
                        acc_nxt = rem[ACC_W-1:0];
                    end else begin
                        acc_nxt = sum[ACC_W-1:0];
                    end
                end
                default: begin
                    fire    = 1'b0;
                    acc_nxt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= acc_nxt;
            tick <= fire;
        end
    end

    // R4
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc < den);

    // R3
    restart_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cur_st == ST_RESTART) && (acc == '0));

    // R3
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_RESTART) |=> !tick);

    // R6
    every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_COUNT && !restart && num == den) |=> tick);

endmodule

// File: rtl/utk_usec_cnt.sv
module utk_usec_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == $past(count) + CNT_W'(1));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

    // R9
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&count)) |=> count == '0);

endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
    parameter int          FLD_W   = 8,
    parameter int          CNT_W   = 32,
    parameter logic [15:0] RST_CFG = 16'h000B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_q,
    output logic             tick,
    output logic [CNT_W-1:0] usec_count
);
    localparam int CFG_W = 2 * FLD_W;

    logic [FLD_W:0] num;
    logic [FLD_W:0] den;
    logic           fire;

    utk_cfg_reg #(
        .FLD_W   (FLD_W),
        .RST_CFG (RST_CFG[CFG_W-1:0])
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata[CFG_W-1:0]),
        .cfg_q (cfg_q[CFG_W-1:0]),
        .num   (num),
        .den   (den)
    );

    generate
        if (CFG_W < 16) begin : g_pad
            assign cfg_q[15:CFG_W] = '0;
        end
    endgenerate

    utk_frac_acc #(
        .FLD_W (FLD_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .num     (num),
        .den     (den),
        .fire    (fire),
        .tick    (tick)
    );

    utk_usec_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .count (usec_count)
    );

    // R7
    tick_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> usec_count != $past(usec_count));

    // R8
    keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(usec_count));

endmodule

// File: tb/sim_usec_tick_gen.sv
`timescale 1ns/1ps
module sim_usec_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic        tick;
    logic [31:0] usec_count;
    logic [15:0] cfg_q1;
    logic        tick1;
    logic [7:0]  cnt1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    usec_tick_gen u0 (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
        .cfg_q (cfg_q), .tick (tick), .usec_count (usec_count)
    );

    usec_tick_gen #(.CNT_W(8), .RST_CFG(16'h0000)) u1 (
        .clk (clk), .rst_n (rst_n), .cfg_wr (1'b0), .cfg_wdata (16'h0000),
        .cfg_q (cfg_q1), .tick (tick1), .usec_count (cnt1)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] val);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = val;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        check(cfg_q == val, "R2 cfg_q after write", cfg_q, val);
        check(tick == 1'b0, "R3 tick at write edge", tick, 0);
        @(posedge clk); #1;
        check(tick == 1'b0, "R3 tick in restart cycle", tick, 0);
    endtask

    // Writes a setting and checks ticks, spacing and counter steps
    task automatic t_window(input logic [15:0] val);
        int p, q, lo, hi, ticks, last, first;
        logic [31:0] c0, cq;
        p = int'(val[15:8]) + 1;
        q = int'(val[7:0]) + 1;
        if (p > q) p = q;
        lo = q / p;
        hi = (q + p - 1) / p;
        ticks = 0; last = -1; first = -1;
        do_write(val);
        c0 = usec_count;
        cq = c0;
        for (int i = 1; i <= 2 * q; i++) begin
            @(posedge clk); #1;
            if (tick) begin
                if (i <= q) ticks++;
                if (first < 0) first = i;
                if (last >= 0)
                    check((i - last) == lo || (i - last) == hi, "R5 tick spacing", i - last, lo);
                last = i;
            end
            if (i == q) cq = usec_count;
        end
        check(ticks == p, "R4 ticks per window", ticks, p);
        check(cq - c0 == 32'(p), "R7 counter step over window", cq - c0, p);
        if (val[15:8] == 8'h00)
            check(first == q, "R10 first integer tick", first, q);
        if (val[15:8] > val[7:0])
            check(first == 1, "R6 clamped ratio ticks at once", first, 1);
    endtask

    task automatic t_reset;
        check(cfg_q == 16'h000B, "R1 reset cfg", cfg_q, 16'h000B);
        check(usec_count == 0, "R1 reset count", usec_count, 0);
        check(tick == 1'b0, "R1 reset tick", tick, 0);
    endtask

    task automatic t_keep_count;
        logic [31:0] c;
        int guard = 0;
        do begin
            @(posedge clk); #1;
            guard++;
        end while (!tick && guard < 100);
        c = usec_count;
        do_write(16'h000C);
        check(usec_count == c, "R8 count kept across write", usec_count, c);
        check(c != 0, "R8 count nonzero before write", c, 1);
    endtask

    task automatic t_wrap;
        logic [7:0] prev;
        int wraps = 0;
        prev = cnt1;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #1;
            if (i < 4)
                check(cnt1 == prev + 8'd1, "R9 step on wrap counter", cnt1, prev + 8'd1);
            if (prev == 8'hFF) begin
                wraps++;
                check(cnt1 == 8'h00, "R9 wrap to zero", cnt1, 0);
            end
            prev = cnt1;
        end
        check(wraps >= 1, "R9 wrap observed", wraps, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_window(16'h000B);
        t_keep_count();
        t_window(16'h000C);
        t_window(16'h0019);
        t_window(16'h002F);
        t_window(16'h043F);
        t_window(16'h0453);
        t_window(16'h045F);
        t_window(16'h04BF);
        t_window(16'h0503);
        t_window(16'h0302);
        t_wrap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule